// File: doc/BRIEF.md
# Serial Transfer Busy Tracker

This unit keeps the busy status of a serial peripheral that can run as bus master or as slave. It watches pulses from the shift engine that mark the start and the end of each frame. It also watches the enable, the role select, receive-only mode, whether the transmit queue is empty, and a mode-fault input. From these it keeps one registered busy flag. The shift engine reads the flag to avoid starting a transfer on a bus that is already in use. Software reads the same flag through a status port.

As master, the flag stays set across a chain of frames as long as more data is ready to go out, and it drops when the chain ends. As slave, the flag always goes low for a fixed gap after every frame. The gap is measured in serial clock edges, which arrive as single-cycle ticks. A master-side mode fault or a disable clears the flag at once. Software writes to the flag are accepted on the status port and have no effect.

Top module: `serial_busy_tracker`

## Requirements
- R1: After reset, `busy` and `stat_busy` read 0.
- R2: A `xfer_start` pulse sampled while `enable`=1 makes `busy` read 1 one cycle later. The exceptions are a master fault in the same cycle (R4) and an open slave gap (R8).
- R3: While `enable`=0, `busy` reads 0 from the following cycle on, and `xfer_start` pulses are ignored. After `enable` returns to 1, `busy` stays 0 until a new `xfer_start` pulse arrives.
- R4: With `is_master`=1 and `enable`=1, a sampled `mode_fault` clears `busy` in the next cycle. This holds even when `xfer_start` is high in the same cycle.
- R5: With `is_master`=0, `mode_fault` has no effect on `busy`.
- R6: As master, an `xfer_end` with `txq_empty`=1 and `rx_only`=0 clears `busy` in the next cycle.
- R7: As master, an `xfer_end` with `txq_empty`=0 or `rx_only`=1 leaves `busy` at 1.
- R8: As slave, `xfer_end` clears `busy` in the next cycle. `busy` then stays 0 until GAP_TICKS `sclk_tick` pulses have been sampled after the end pulse, even if `xfer_start` arrives during that gap. After the gap, `busy` reads 1 only if a start arrived and no end followed it.
- R9: A write on the status port (`stat_wr`=1 with any `stat_wdata`) leaves `busy` and `stat_busy` unchanged. `stat_busy` always equals `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Peripheral enable |
| is_master | input | 1 | 1 = master role, 0 = slave role |
| rx_only | input | 1 | Master receive-only mode |
| xfer_start | input | 1 | Frame start pulse from the shift engine |
| xfer_end | input | 1 | Frame end pulse from the shift engine |
| txq_empty | input | 1 | Transmit queue empty |
| mode_fault | input | 1 | Mode fault detected |
| sclk_tick | input | 1 | One pulse per serial clock edge |
| stat_wr | input | 1 | Software write strobe to the status bit |
| stat_wdata | input | 1 | Software write data (ignored) |
| busy | output | 1 | Busy flag to the shift engine |
| stat_busy | output | 1 | Busy flag as read by software |

## Verification
On the master side, the frame-end decision is swept over all four combinations of queue-empty and receive-only. This separates the chaining case from the closing case. A mode fault is applied in both roles, with and without a start pulse in the same cycle, so the fault priority and the slave-side immunity are each tested. On the slave side, the start of the next frame is moved through every tick position inside and past the gap, plus a run with no start at all. This shows whether the gap is timed by ticks and whether it holds against an early start. Disable and status-port writes are applied with the flag both set and clear.

// File: rtl/busy_trk_pkg.sv
package busy_trk_pkg;

  typedef struct packed {
    logic enable;
    logic is_master;
    logic rx_only;
  } busy_cfg_t;

  function automatic logic master_chains(input busy_cfg_t cfg, input logic txq_empty);
    return cfg.is_master & (~txq_empty | cfg.rx_only);
  endfunction

endpackage

// File: rtl/busy_frame_track.sv
module busy_frame_track
  import busy_trk_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  busy_cfg_t cfg,
  input  logic      xfer_start,
  input  logic      xfer_end,
  input  logic      txq_empty,
  input  logic      mode_fault,
  output logic      frame_d,
  output logic      frame_q
);

  logic fault_hit;

  assign fault_hit = cfg.is_master & mode_fault;

  // Priority: disable, then master fault, then start, then end
  always_comb begin
    frame_d = frame_q;
    if (!cfg.enable) begin
      frame_d = 1'b0;
    end else if (fault_hit) begin
      frame_d = 1'b0;
    end else if (xfer_start) begin
      frame_d = 1'b1;
    end else if (xfer_end) begin
      frame_d = master_chains(cfg, txq_empty);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= 1'b0;
    end else if (frame_d != frame_q) begin
      frame_q <= frame_d;
    end
  end

endmodule

// File: rtl/busy_gap_timer.sv
module busy_gap_timer #(
  parameter int GAP_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic is_master,
  input  logic xfer_end,
  input  logic sclk_tick,
  output logic gap_d,
  output logic gap_q
);

  generate
    if (GAP_TICKS == 0) begin : g_no_gap
      assign gap_d = 1'b0;
      assign gap_q = 1'b0;
    end else begin : g_gap
      localparam int CW = $clog2(GAP_TICKS + 1);
      localparam logic [CW-1:0] LOAD = CW'(GAP_TICKS);

      logic [CW-1:0] cnt_q;
      logic [CW-1:0] cnt_d;
      logic          cnt_en;

      always_comb begin
        cnt_d = cnt_q;
        if (!enable) begin
          cnt_d = '0;
        end else if (!is_master && xfer_end) begin
          cnt_d = LOAD;
        end else if (sclk_tick && cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end
      end

      assign cnt_en = (cnt_d != cnt_q);
      assign gap_d  = (cnt_d != '0);
      assign gap_q  = (cnt_q != '0);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else if (cnt_en) begin
          cnt_q <= cnt_d;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/busy_flag_reg.sv
module busy_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_d,
  input  logic stat_wr,
  input  logic stat_wdata,
  output logic busy,
  output logic stat_busy
);

  logic busy_q;
  logic upd_en;

  // Status writes reach this point and are dropped: the bit is read-only
  logic unused_wr;
  assign unused_wr = stat_wr & stat_wdata;

  assign upd_en = (busy_d != busy_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
    end else if (upd_en) begin
      busy_q <= busy_d;
    end
  end

  assign busy      = busy_q;
  assign stat_busy = busy_q;

endmodule

// File: rtl/serial_busy_tracker.sv
module serial_busy_tracker
  import busy_trk_pkg::*;
#(
  parameter int GAP_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic is_master,
  input  logic rx_only,
  input  logic xfer_start,
  input  logic xfer_end,
  input  logic txq_empty,
  input  logic mode_fault,
  input  logic sclk_tick,
  input  logic stat_wr,
  input  logic stat_wdata,
  output logic busy,
  output logic stat_busy
);

  busy_cfg_t cfg;
  logic      frame_d, frame_q;
  logic      gap_d, gap_q;
  logic      busy_d;

  assign cfg = '{enable: enable, is_master: is_master, rx_only: rx_only};

  busy_frame_track u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg       (cfg),
    .xfer_start(xfer_start),
    .xfer_end  (xfer_end),
    .txq_empty (txq_empty),
    .mode_fault(mode_fault),
    .frame_d   (frame_d),
    .frame_q   (frame_q)
  );

  busy_gap_timer #(.GAP_TICKS(GAP_TICKS)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .is_master(is_master),
    .xfer_end (xfer_end),
    .sclk_tick(sclk_tick),
    .gap_d    (gap_d),
    .gap_q    (gap_q)
  );

  assign busy_d = frame_d & ~gap_d;

  busy_flag_reg u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy_d    (busy_d),
    .stat_wr   (stat_wr),
    .stat_wdata(stat_wdata),
    .busy      (busy),
    .stat_busy (stat_busy)
  );

endmodule

// File: rtl/serial_busy_tracker_chk.sv
module serial_busy_tracker_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic is_master,
  input logic rx_only,
  input logic xfer_start,
  input logic xfer_end,
  input logic txq_empty,
  input logic mode_fault,
  input logic busy,
  input logic stat_busy,
  input logic frame_q,
  input logic gap_q
);

  a_r3_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !busy);

  a_r4_fault_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && is_master && mode_fault) |=> !busy);

  a_r2_master_start_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && is_master && xfer_start && !mode_fault) |=> busy);

  a_r6_master_close: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && is_master && xfer_end && !xfer_start && !mode_fault && txq_empty && !rx_only) |=> !busy);

  a_r7_master_chain: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && is_master && busy && xfer_end && !mode_fault && (!txq_empty || rx_only)) |=> busy);

  a_r8_slave_end_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !is_master && xfer_end) |=> !busy);

  a_r8_gap_holds_low: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q |-> !busy);

  a_r9_status_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    stat_busy == busy);

  a_r2_busy_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> frame_q);

endmodule

bind serial_busy_tracker serial_busy_tracker_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .is_master (is_master),
  .rx_only   (rx_only),
  .xfer_start(xfer_start),
  .xfer_end  (xfer_end),
  .txq_empty (txq_empty),
  .mode_fault(mode_fault),
  .busy      (busy),
  .stat_busy (stat_busy),
  .frame_q   (frame_q),
  .gap_q     (gap_q)
);

// File: tb/test_serial_busy_tracker.sv
module test_serial_busy_tracker;

  localparam int GAP = 2;

  logic clk, rst_n;
  logic enable, is_master, rx_only, xfer_start, xfer_end;
  logic txq_empty, mode_fault, sclk_tick, stat_wr, stat_wdata;
  logic busy, stat_busy;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  serial_busy_tracker #(.GAP_TICKS(GAP)) i_serial_busy_tracker (
    .clk(clk), .rst_n(rst_n), .enable(enable), .is_master(is_master),
    .rx_only(rx_only), .xfer_start(xfer_start), .xfer_end(xfer_end),
    .txq_empty(txq_empty), .mode_fault(mode_fault), .sclk_tick(sclk_tick),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .busy(busy), .stat_busy(stat_busy)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic clr_pulses();
    xfer_start = 0; xfer_end = 0; mode_fault = 0; sclk_tick = 0;
    stat_wr = 0; stat_wdata = 0;
  endtask

  task automatic check(input string req, input logic exp);
    checks++;
    if (busy !== exp || stat_busy !== exp) begin
      errors++;
      $display("FAIL %s: busy=%b stat_busy=%b expected=%b at %0t",
               req, busy, stat_busy, exp, $time);
    end
  endtask

  task automatic pulse_start();
    xfer_start = 1; cyc(); clr_pulses();
  endtask

  task automatic pulse_end();
    xfer_end = 1; cyc(); clr_pulses();
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; enable = 0; is_master = 1; rx_only = 0; txq_empty = 1;
    clr_pulses();
    repeat (3) cyc();
    check("R1 reset", 1'b0);
    rst_n = 1;
    cyc();
    check("R1 after release", 1'b0);

    // R3: start ignored while disabled
    pulse_start();
    check("R3 start while disabled", 1'b0);

    // R6/R7: master end sweep
    for (int te = 0; te < 2; te++) begin
      for (int ro = 0; ro < 2; ro++) begin
        enable = 1; is_master = 1; txq_empty = 1; rx_only = 0;
        pulse_start();
        check("R2 master start", 1'b1);
        txq_empty = logic'(te); rx_only = logic'(ro);
        pulse_end();
        check((te == 1 && ro == 0) ? "R6 master close" : "R7 master chain",
              logic'(te == 0 || ro == 1));
        enable = 0; cyc();
        check("R3 disable clears", 1'b0);
        enable = 1; cyc(); cyc();
        check("R3 stays low after re-enable", 1'b0);
      end
    end
    txq_empty = 1; rx_only = 0;

    // R4/R5: fault in both roles, with and without simultaneous start
    for (int m = 0; m < 2; m++) begin
      for (int st = 0; st < 2; st++) begin
        is_master = logic'(m);
        pulse_start();
        check("R2 start before fault", 1'b1);
        mode_fault = 1; xfer_start = logic'(st); cyc(); clr_pulses();
        check(m == 1 ? "R4 master fault clears" : "R5 slave fault ignored",
              logic'(m == 0));
        if (m == 0) begin
          pulse_end();
          repeat (GAP) begin sclk_tick = 1; cyc(); clr_pulses(); end
        end
      end
    end

    // R9: status writes ignored with flag set and clear
    is_master = 1;
    pulse_start();
    stat_wr = 1; stat_wdata = 0; cyc(); clr_pulses();
    check("R9 write 0 while busy", 1'b1);
    txq_empty = 1; pulse_end();
    stat_wr = 1; stat_wdata = 1; cyc(); clr_pulses();
    check("R9 write 1 while idle", 1'b0);

    // R8: slave gap sweep, start placed at tick position s (5 = no start)
    is_master = 0;
    for (int s = 1; s <= 5; s++) begin
      pulse_start();
      check("R2 slave start", 1'b1);
      pulse_end();
      check("R8 slave end drops", 1'b0);
      for (int i = 1; i <= 4; i++) begin
        sclk_tick = 1;
        xfer_start = logic'(i == s);
        cyc(); clr_pulses();
        check("R8 gap timing", logic'(i >= GAP && i >= s));
      end
      if (s == 5) begin
        pulse_start();
        check("R8 start after gap", 1'b1);
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule